// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block refreshes a passive-matrix graphic LCD panel that has its own row and column drivers but no controller. It walks a one-bit-per-pixel frame buffer through a synchronous read port and sends the pixels to the panel four at a time. Alongside the pixels it produces the panel's control strobes: a nibble shift clock, a line latch pulse, a frame-start marker and an alternating drive-polarity signal. Panel size, the upper/lower split and every timing interval are parameters given in system clock cycles. An elaboration-time check rejects any setting that breaks the panel's minimum timing at the given clock period.

Each line of the scan has a shift phase of four-pixel nibbles, followed by a quiet interval, a latch pulse and a recovery interval. In split-screen mode two lanes run in lock-step from separate halves of the buffer. They drive two 4-bit buses that share one set of strobes. Each lane fetches the next byte ahead of time, so the shift clock keeps a fixed rhythm across byte boundaries.

Top module: `lcd_scan_gen`

## Requirements
- R1: Each rising edge of `lcd_shift` carries one nibble. Exactly COLS/4 rising edges of `lcd_shift` occur between consecutive `lcd_latch` pulses.
- R2: Pixels appear most significant bit first. Byte bits 7:4 form the first nibble and bits 3:0 the second. Within a nibble, bit 3 of the bus is the leftmost pixel. Upper-lane row r uses buffer addresses r*COLS/8 upward, so a value of 0xF0 at address 0 gives first nibbles 0xF then 0x0.
- R3: One `lcd_latch` pulse follows the data of every row. Rows are scanned in increasing order, with ROWS/2 lines per frame in split mode (ROWS otherwise), and the scan then wraps to row 0.
- R4: `lcd_frame` is high around the latch pulse of row 0 only. It rises at least 100 ns before that pulse rises and falls at least 100 ns after that pulse falls.
- R5: `lcd_polarity` inverts exactly once per frame, in the cycle `lcd_frame` rises. It holds its value otherwise and is 1 during the first frame after reset.
- R6: `lcd_shift` high and low phases last at least 110 ns each, and its period is at least 330 ns.
- R7: `lcd_latch` is high for at least 125 ns, and its period is at least 1000 ns. `lcd_shift` stays low while `lcd_latch` is high. The last shift fall comes at least 125 ns before the latch falls, and the next shift fall comes at least 80 ns after it.
- R8: Nibble data is stable for at least 100 ns before and 100 ns after each rising edge of `lcd_shift`.
- R9: In split mode the lower bus shows row r of the lower half, starting at buffer address (ROWS/2 + r)*COLS/8. It is clocked by the same strobes as the upper bus.
- R10: During reset all panel outputs are 0, the upper read address is 0 and the lower read address is (ROWS/2)*COLS/8.
- R11: Within a line, consecutive rising edges of `lcd_shift` are exactly 2*CL2_HALF cycles apart, with no stretch at byte boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_addr_up | output | ADDR_W | Upper-lane frame-buffer read address |
| fb_data_up | input | 8 | Upper-lane read data, one cycle after address |
| fb_addr_lo | output | ADDR_W | Lower-lane frame-buffer read address |
| fb_data_lo | input | 8 | Lower-lane read data, one cycle after address |
| lcd_d_up | output | 4 | Upper-half pixel nibble |
| lcd_d_lo | output | 4 | Lower-half pixel nibble |
| lcd_shift | output | 1 | Nibble shift clock |
| lcd_latch | output | 1 | Line latch pulse |
| lcd_frame | output | 1 | Frame-start marker |
| lcd_polarity | output | 1 | Drive-polarity alternation |

## Verification
The assertions check the edge-to-edge intervals on every cycle: shift clock phases and period, latch width and period, shift/latch edge spacing, data setup and hold, frame-marker setup and hold, polarity changing only with the frame marker, and the fixed shift rhythm inside a line. Only the bench scenarios can show that the right pixels arrive in the right order. They rebuild each row from the captured nibbles of both lanes and compare it with buffer contents that change from frame to frame. They also confirm the reset values, the nibble count per line, the row sequence with its wrap, and the frame-by-frame polarity sequence.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the LCD scan generator.
// Assumes all timing limits are expressed in nanoseconds and the clock period is a whole number of ns.
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        PH_SHIFT = 2'd0,
        PH_PRE   = 2'd1,
        PH_LATCH = 2'd2,
        PH_POST  = 2'd3
    } phase_t;

    // Smallest cycle count covering a duration in ns.
    function automatic int to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Saturating 16-bit increment for interval counters.
    function automatic logic [15:0] sat_inc(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    // True when the divider settings meet every panel timing minimum.
    function automatic bit cfg_ok(input int clk_ns, input int half, input int pre,
                                  input int lw, input int post, input int nib);
        return (half >= to_cyc(110, clk_ns)) &&
               (2 * half >= to_cyc(330, clk_ns)) &&
               (half >= to_cyc(100, clk_ns)) &&
               (lw >= to_cyc(125, clk_ns)) &&
               (pre + lw >= to_cyc(125, clk_ns)) &&
               (post + 2 * half >= to_cyc(80, clk_ns)) &&
               (pre >= to_cyc(100, clk_ns)) && (pre >= 1) &&
               (post >= to_cyc(100, clk_ns)) && (post >= 1) &&
               (nib * 2 * half + pre + lw + post >= to_cyc(1000, clk_ns));
    endfunction

endpackage

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
// Line/frame sequencer: steps through shift, pre-latch gap, latch and post-latch gap
// for every line. Strobes are registered from the next state so they are glitch free.
// Assumes NIB is even, and that every interval parameter is at least 1.
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int NIB      = 8,
    parameter int LINES    = 4,
    parameter int CL2_HALF = 17,
    parameter int PRE_GAP  = 10,
    parameter int LATCH_W  = 13,
    parameter int POST_GAP = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic ld,
    output logic ld_hi,
    output logic shift,
    output logic latch,
    output logic frame,
    output logic pol
);
    localparam int SPAN = 2 * CL2_HALF;
    localparam int M1   = (SPAN > PRE_GAP) ? SPAN : PRE_GAP;
    localparam int M2   = (LATCH_W > POST_GAP) ? LATCH_W : POST_GAP;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int NW   = (NIB > 1) ? $clog2(NIB) : 1;
    localparam int RW   = (LINES > 1) ? $clog2(LINES) : 1;

    phase_t          ph, ph_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic [NW-1:0]   nib, nib_n;
    logic [RW-1:0]   row, row_n;
    logic            pol_n;

    // Next-state decode for phase, interval counter, nibble index, row and polarity.
    always_comb begin
        ph_n  = ph;
        cnt_n = cnt + CW'(1);
        nib_n = nib;
        row_n = row;
        pol_n = pol;
        unique case (ph)
            PH_SHIFT: if (cnt == CW'(SPAN - 1)) begin
                cnt_n = '0;
                if (nib == NW'(NIB - 1)) begin
                    ph_n = PH_PRE;
                    if (row == '0) pol_n = ~pol;
                end else begin
                    nib_n = nib + NW'(1);
                end
            end
            PH_PRE: if (cnt == CW'(PRE_GAP - 1)) begin
                cnt_n = '0;
                ph_n  = PH_LATCH;
            end
            PH_LATCH: if (cnt == CW'(LATCH_W - 1)) begin
                cnt_n = '0;
                ph_n  = PH_POST;
            end
            PH_POST: if (cnt == CW'(POST_GAP - 1)) begin
                cnt_n = '0;
                ph_n  = PH_SHIFT;
                nib_n = '0;
                row_n = (row == RW'(LINES - 1)) ? '0 : row + RW'(1);
            end
        endcase
    end

    // Load request: a new nibble period starts on this edge.
    assign ld    = (ph_n == PH_SHIFT) && (cnt_n == '0);
    assign ld_hi = ld && !nib_n[0];

    // State and registered panel strobes; reset parks in the recovery gap of the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_POST;
            cnt   <= '0;
            nib   <= '0;
            row   <= RW'(LINES - 1);
            shift <= 1'b0;
            latch <= 1'b0;
            frame <= 1'b0;
            pol   <= 1'b0;
        end else begin
            ph    <= ph_n;
            cnt   <= cnt_n;
            nib   <= nib_n;
            row   <= row_n;
            shift <= (ph_n == PH_SHIFT) && (cnt_n >= CW'(CL2_HALF));
            latch <= (ph_n == PH_LATCH);
            frame <= (ph_n != PH_SHIFT) && (row_n == '0);
            pol   <= pol_n;
        end
    end

endmodule

// File: rtl/lcd_nibble_lane.sv
`timescale 1ns/1ps
// One data lane: walks a contiguous region of the frame buffer and presents its bytes
// as two nibbles, high half first. Keeps the address of the upcoming byte on the read
// port, so that byte is ready at the next high-nibble load (one-cycle read latency).
// Assumes loads are at least two cycles apart.
module lcd_nibble_lane #(
    parameter int AW   = 5,
    parameter int BASE = 0,
    parameter int SPAN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          ld_hi,
    input  logic [7:0]    fb_data,
    output logic [AW-1:0] fb_addr,
    output logic [3:0]    dat
);
    localparam logic [AW-1:0] FIRST = AW'(BASE);
    localparam logic [AW-1:0] LAST  = AW'(BASE + SPAN - 1);

    logic [3:0] low_q;

    // Prefetch address advance and nibble presentation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_addr <= FIRST;
            dat     <= '0;
            low_q   <= '0;
        end else if (ld) begin
            if (ld_hi) begin
                dat     <= fb_data[7:4];
                low_q   <= fb_data[3:0];
                fb_addr <= (fb_addr == LAST) ? FIRST : fb_addr + AW'(1);
            end else begin
                dat <= low_q;
            end
        end
    end

endmodule

// File: rtl/lcd_scan_gen.sv
`timescale 1ns/1ps
// Multiplexed LCD scan timing generator. It reads a 1-bit-per-pixel frame buffer and
// drives a controller-less panel with nibble data, shift clock, line latch, frame
// marker and polarity. Assumes COLS is a multiple of 8 and, with DUAL set, that ROWS
// is even. The frame buffer is one byte per 8 pixels, row-major: upper half first,
// then lower half.
module lcd_scan_gen
    import lcd_scan_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int COLS     = 32,
    parameter int ROWS     = 8,
    parameter int DUAL     = 1,
    parameter int CL2_HALF = 17,
    parameter int PRE_GAP  = 10,
    parameter int LATCH_W  = 13,
    parameter int POST_GAP = 10,
    parameter int ADDR_W   = (ROWS * COLS / 8 > 1) ? $clog2(ROWS * COLS / 8) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] fb_addr_up,
    input  logic [7:0]        fb_data_up,
    output logic [ADDR_W-1:0] fb_addr_lo,
    input  logic [7:0]        fb_data_lo,
    output logic [3:0]        lcd_d_up,
    output logic [3:0]        lcd_d_lo,
    output logic              lcd_shift,
    output logic              lcd_latch,
    output logic              lcd_frame,
    output logic              lcd_polarity
);
    localparam int LINES = (DUAL != 0) ? ROWS / 2 : ROWS;
    localparam int BPR   = COLS / 8;
    localparam int NIB   = COLS / 4;
    localparam int SPAN  = LINES * BPR;

    // Elaboration guard: divider settings must satisfy the panel minimums.
    if (!cfg_ok(CLK_NS, CL2_HALF, PRE_GAP, LATCH_W, POST_GAP, NIB)) begin : g_bad_timing
        $error("lcd_scan_gen: divider parameters violate panel timing");
    end
    if ((COLS % 8) != 0) begin : g_bad_cols
        $error("lcd_scan_gen: COLS must be a multiple of 8");
    end

    logic ld, ld_hi;

    lcd_scan_seq #(
        .NIB(NIB), .LINES(LINES), .CL2_HALF(CL2_HALF),
        .PRE_GAP(PRE_GAP), .LATCH_W(LATCH_W), .POST_GAP(POST_GAP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_hi(ld_hi),
        .shift(lcd_shift), .latch(lcd_latch), .frame(lcd_frame), .pol(lcd_polarity)
    );

    lcd_nibble_lane #(.AW(ADDR_W), .BASE(0), .SPAN(SPAN)) u_up (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_hi(ld_hi),
        .fb_data(fb_data_up), .fb_addr(fb_addr_up), .dat(lcd_d_up)
    );

    if (DUAL != 0) begin : g_lower
        lcd_nibble_lane #(.AW(ADDR_W), .BASE(SPAN), .SPAN(SPAN)) u_lo (
            .clk(clk), .rst_n(rst_n), .ld(ld), .ld_hi(ld_hi),
            .fb_data(fb_data_lo), .fb_addr(fb_addr_lo), .dat(lcd_d_lo)
        );
    end else begin : g_single
        assign fb_addr_lo = '0;
        assign lcd_d_lo   = '0;
    end

endmodule

// File: rtl/lcd_scan_chk.sv
`timescale 1ns/1ps
// Timing checker for lcd_scan_gen. It measures the intervals between panel strobe
// edges in clock cycles and compares them with the panel minimums. Bound to every
// instance of the top module.
module lcd_scan_chk
    import lcd_scan_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int CL2_HALF = 17
) (
    input logic       clk,
    input logic       rst_n,
    input logic       shift,
    input logic       latch,
    input logic       frame,
    input logic       pol,
    input logic [3:0] d_up,
    input logic [3:0] d_lo
);
    localparam logic [15:0] MIN_C2H = 16'(to_cyc(110, CLK_NS));
    localparam logic [15:0] MIN_C2P = 16'(to_cyc(330, CLK_NS));
    localparam logic [15:0] MIN_C1H = 16'(to_cyc(125, CLK_NS));
    localparam logic [15:0] MIN_C1P = 16'(to_cyc(1000, CLK_NS));
    localparam logic [15:0] MIN_SL  = 16'(to_cyc(125, CLK_NS));
    localparam logic [15:0] MIN_LH  = 16'(to_cyc(80, CLK_NS));
    localparam logic [15:0] MIN_DAT = 16'(to_cyc(100, CLK_NS));
    localparam logic [15:0] MIN_FRM = 16'(to_cyc(100, CLK_NS));
    localparam logic [15:0] RHYTHM  = 16'(2 * CL2_HALF);

    logic [7:0]  dat, dat_d;
    logic        sh_d, la_d, seen_c2r, seen_c1r, lat_between;
    logic [15:0] c2_hi, c2_lo, s_c2r, s_c2f, c1_hi, s_c1r, s_c1f, fr_on, s_dc;

    assign dat = {d_up, d_lo};

    // Interval counters between strobe edges, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_d <= '0;  sh_d <= 1'b0;  la_d <= 1'b0;
            seen_c2r <= 1'b0;  seen_c1r <= 1'b0;  lat_between <= 1'b0;
            c2_hi <= '0;  c2_lo <= '0;  c1_hi <= '0;  fr_on <= '0;
            s_c2r <= '1;  s_c2f <= '1;  s_c1r <= '1;  s_c1f <= '1;  s_dc <= '1;
        end else begin
            dat_d <= dat;
            sh_d  <= shift;
            la_d  <= latch;
            c2_hi <= shift ? sat_inc(c2_hi) : '0;
            c2_lo <= !shift ? sat_inc(c2_lo) : '0;
            c1_hi <= latch ? sat_inc(c1_hi) : '0;
            fr_on <= frame ? sat_inc(fr_on) : '0;
            s_c2r <= (shift && !sh_d) ? 16'd1 : sat_inc(s_c2r);
            s_c2f <= (!shift && sh_d) ? 16'd1 : sat_inc(s_c2f);
            s_c1r <= (latch && !la_d) ? 16'd1 : sat_inc(s_c1r);
            s_c1f <= (!latch && la_d) ? 16'd1 : sat_inc(s_c1f);
            s_dc  <= (dat != dat_d) ? 16'd1 : sat_inc(s_dc);
            seen_c2r <= seen_c2r | (shift && !sh_d);
            seen_c1r <= seen_c1r | (latch && !la_d);
            if (latch && !la_d)       lat_between <= 1'b1;
            else if (shift && !sh_d)  lat_between <= 1'b0;
        end
    end

    a_r6_shift_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift) |-> c2_hi >= MIN_C2H);
    a_r6_shift_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift) |-> c2_lo >= MIN_C2H);
    a_r6_shift_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift) && seen_c2r |-> s_c2r >= MIN_C2P);
    a_r11_fixed_rhythm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift) && seen_c2r && !lat_between |-> s_c2r == RHYTHM);
    a_r7_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> c1_hi >= MIN_C1H);
    a_r7_latch_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) && seen_c1r |-> s_c1r >= MIN_C1P);
    a_r7_shift_to_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> s_c2f >= MIN_SL);
    a_r7_latch_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift) |-> s_c1f >= MIN_LH);
    a_r7_shift_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !shift);
    a_r8_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift) |-> s_dc >= MIN_DAT);
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dat) |-> s_c2r >= MIN_DAT);
    a_r4_frame_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) && frame |-> fr_on >= MIN_FRM);
    a_r4_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame) |-> s_c1f >= MIN_FRM);
    a_r5_polarity_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol) |-> $rose(frame));

endmodule

bind lcd_scan_gen lcd_scan_chk #(.CLK_NS(CLK_NS), .CL2_HALF(CL2_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift(lcd_shift), .latch(lcd_latch),
    .frame(lcd_frame), .pol(lcd_polarity), .d_up(lcd_d_up), .d_lo(lcd_d_lo)
);

// File: tb/sim_lcd_scan_gen.sv
`timescale 1ns/1ps
// Bench for lcd_scan_gen. It models the frame buffer, rebuilds every scanned row from
// the nibble buses and compares it with the buffer contents. It also checks the strobe
// sequence and timing from the ports.
module sim_lcd_scan_gen;
    localparam int COLS = 32, ROWS = 8, DUAL = 1;
    localparam int CH = 17, PG = 10, LW = 13, QG = 10;
    localparam int LINES = ROWS / 2, BPR = COLS / 8, NIB = COLS / 4;
    localparam int DEPTH = ROWS * BPR, AW = $clog2(DEPTH);
    localparam int FRAMES = 5, LIMIT = 20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] a_up, a_lo;
    logic [7:0] q_up, q_lo;
    logic [3:0] d_up, d_lo;
    logic shf, lat, frm, pol;
    logic [7:0] mem [DEPTH];
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    // Synchronous frame-buffer read ports, one cycle latency.
    always_ff @(posedge clk) begin
        q_up <= mem[a_up];
        q_lo <= mem[a_lo];
    end

    lcd_scan_gen #(
        .CLK_NS(10), .COLS(COLS), .ROWS(ROWS), .DUAL(DUAL),
        .CL2_HALF(CH), .PRE_GAP(PG), .LATCH_W(LW), .POST_GAP(QG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fb_addr_up(a_up), .fb_data_up(q_up),
        .fb_addr_lo(a_lo), .fb_data_lo(q_lo), .lcd_d_up(d_up), .lcd_d_lo(d_lo),
        .lcd_shift(shf), .lcd_latch(lat), .lcd_frame(frm), .lcd_polarity(pol)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Buffer contents per frame: directed, random, all lit, random, all dark.
    task automatic fill(input int f);
        for (int i = 0; i < DEPTH; i++) begin
            case (f)
                0:       mem[i] = 8'(i * 37 + 5);
                2:       mem[i] = 8'hFF;
                4:       mem[i] = 8'h00;
                default: mem[i] = 8'($urandom);
            endcase
        end
        if (f == 0) mem[0] = 8'hF0;
    endtask

    // Expected pixel row, leftmost pixel at the MSB.
    function automatic logic [COLS-1:0] exp_row(input int base);
        logic [COLS-1:0] v = '0;
        for (int k = 0; k < BPR; k++) v[COLS-1-8*k -: 8] = mem[base + k];
        return v;
    endfunction

    initial begin
        int cyc, row, frame, nib, lat_cnt, hi_len, per, dchg, lat_len;
        logic pshf, plat, m0, in_line;
        logic [7:0] pdat;
        logic [COLS-1:0] cu, cl;
        cyc = 0; row = 0; frame = 0; nib = 0; lat_cnt = 0;
        hi_len = 0; per = 0; dchg = 0; lat_len = 0;
        pshf = 0; plat = 0; m0 = 0; in_line = 0; pdat = '0; cu = '0; cl = '0;
        void'($urandom(32'd4242));
        fill(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk({shf, lat, frm, pol} == 4'b0, "R10", "strobes in reset", {shf, lat, frm, pol}, 0);
        chk({d_up, d_lo} == 8'h00, "R10", "data in reset", {d_up, d_lo}, 0);
        chk(a_up == AW'(0), "R10", "upper address in reset", a_up, 0);
        chk(a_lo == AW'(LINES * BPR), "R10", "lower address in reset", a_lo, LINES * BPR);
        rst_n = 1'b1;
        while (frame < FRAMES && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            per++;
            dchg++;
            if ({d_up, d_lo} != pdat) dchg = 0;
            if (shf) hi_len++;
            if (lat) lat_len++;
            if (shf && !pshf) begin
                // R8: data settled well before the shift edge
                chk(dchg >= 10, "R8", "data setup cycles", dchg, 10);
                if (in_line) chk(per == 2 * CH, "R11", "shift period in line", per, 2 * CH);
                per = 0;
                in_line = 1;
                cu[COLS-1-4*nib -: 4] = d_up;
                cl[COLS-1-4*nib -: 4] = d_lo;
                nib++;
            end
            if (!shf && pshf) begin
                chk(hi_len == CH, "R6", "shift high cycles", hi_len, CH);
                hi_len = 0;
            end
            if (lat && !plat) begin
                chk(nib == NIB, "R1", "nibbles per line", nib, NIB);
                chk(!shf, "R7", "shift low at latch", shf, 0);
                chk(cu == exp_row(row * BPR), "R2", "upper row pixels", cu, exp_row(row * BPR));
                chk(cl == exp_row((LINES + row) * BPR), "R9", "lower row pixels",
                    cl, exp_row((LINES + row) * BPR));
                if (frame == 0 && row == 0)
                    chk(cu[COLS-1 -: 8] == 8'hF0, "R2", "0xF0 at address 0", cu[COLS-1 -: 8], 8'hF0);
                chk(frm == (row == 0), "R4", "frame marker at latch", frm, row == 0);
                if (row == 0) begin
                    if (frame > 0) chk(lat_cnt == LINES, "R3", "latches per frame", lat_cnt, LINES);
                    chk(pol == ((frame == 0) ? 1'b1 : !m0), "R5", "polarity flips per frame",
                        pol, (frame == 0) ? 1 : !m0);
                    m0 = pol;
                    lat_cnt = 0;
                end else begin
                    chk(pol == m0, "R5", "polarity steady in frame", pol, m0);
                end
                lat_cnt++;
                nib = 0; cu = '0; cl = '0; in_line = 0;
            end
            if (!lat && plat) begin
                chk(lat_len == LW, "R7", "latch high cycles", lat_len, LW);
                lat_len = 0;
                if (row == LINES - 1) begin
                    row = 0;
                    frame++;
                    fill(frame);
                end else begin
                    row++;
                end
            end
            pshf = shf;
            plat = lat;
            pdat = {d_up, d_lo};
        end
        if (cyc >= LIMIT) chk(1'b0, "R3", "watchdog: frames completed", frame, FRAMES);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule